// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns one bus request into a four-state bus cycle on pins that carry address, status and data in turn. A request holds a 20-bit address, a direction, a memory-or-I/O select, a write word, an active-low high-byte enable and a 2-bit segment tag. The block walks through states T1, T2, T3 and T4. In T1 it pulses an address-latch strobe and puts the address on the shared pins. From T2 on, the upper address pins carry status, and the low pins carry the write data or are released for a read.

Three status lines encode the cycle type so that an external command decoder can act on them. A mode strap input selects one of two control styles. When the strap is high, the block also drives its own active-low read and write strobes. When the strap is low, only the status lines describe the cycle.

A demultiplexing latch captures the address as the strobe falls and holds it for memory. A read returns the sampled data with a one-cycle done pulse.

Requests use a valid/ready handshake. The block raises ready only when idle or in T4, and a request is taken on a clock edge where valid and ready are both high. The requester must hold its fields steady while valid is high and ready is low. The done pulse has no ready signal and cannot be back-pressured, so the consumer must take it in the cycle it appears.

Top module: `mxbus_seq`

## Requirements
- R1: While reset is held and directly after it, ale is 0, ad_oe is 0, rd_n and wr_n are 1, status is 3'b111, req_ready is 1, rsp_valid is 0 and latched_addr is 0.
- R2: An accepted request is followed by T1 on the next clock, then T2, T3 and T4, one clock each. ale is 1 only in T1, for exactly one clock. req_ready is 1 only when idle and in T4. A request accepted in T4 starts a new T1 at once, and with no request the block goes idle after T4.
- R3: In T1, ad_oe is 1, ad_out carries address bits [15:0], ah_out carries address bits [19:16] and bhe_out carries the request's high-byte enable.
- R4: In T2, T3 and T4, ah_out carries status, with bits [1:0] holding the segment tag and bits [3:2] holding 0, and bhe_out carries 0.
- R5: status holds the cycle code in T1, T2 and T3, and the passive code 3'b111 in T4 and when idle. The cycle codes, written as {io, write}, are: memory read (00) gives 3'b101, memory write (01) gives 3'b110, I/O read (10) gives 3'b001 and I/O write (11) gives 3'b010.
- R6: In a write cycle, ad_oe is 1 and ad_out carries the write word in T2, T3 and T4.
- R7: In a read cycle, ad_oe is 0 in T2, T3 and T4. ad_in is sampled on the clock edge that ends T3, and it appears on rsp_rdata while rsp_valid is 1, which happens during T4 only.
- R8: When mode_min is 1, rd_n is 0 in T2 and T3 of a read cycle, and wr_n is 0 in T2 and T3 of a write cycle. When mode_min is 0, both strobes stay at 1. The two strobes are never 0 together.
- R9: latched_addr takes the T1 address on the clock edge where ale falls. It holds that value through T2 to T4 and through idle, and changes only on the next ale fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_min | input | 1 | Mode strap: 1 makes the block drive its own read/write strobes |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready: high when idle and in T4 |
| req_addr | input | 20 | Cycle address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_bhe_n | input | 1 | High-byte enable, active low |
| req_seg | input | 2 | Segment tag shown in status |
| req_wdata | input | 16 | Write word |
| ad_out | output | 16 | Shared address/data pins, driven value |
| ad_oe | output | 1 | Output enable for the shared pins |
| ad_in | input | 16 | Shared pins, received value |
| ah_out | output | 4 | Upper address / status pins |
| bhe_out | output | 1 | High-byte enable / status pin |
| ale | output | 1 | Address-latch strobe |
| status | output | 3 | Cycle-type status lines |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| latched_addr | output | 20 | Address held by the demultiplexing latch |
| rsp_valid | output | 1 | Done pulse during T4 |
| rsp_rdata | output | 16 | Read data |

## Verification
The bench runs all four cycle kinds (memory read and write, I/O read and write) with both settings of the mode strap. The four kinds catch a wrong status code or a swapped io/write bit. The strap settings show whether the strobes depend on the strap. Address, data and segment patterns use distinct nibbles and opposite bit polarities, so a swapped or misplaced pin field produces a different value. A pair of back-to-back requests checks that a request accepted in T4 starts T1 with no idle state in between. A long idle gap after a cycle shows whether the latch holds its address.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_T1, PH_T2, PH_T3, PH_T4} phase_e;

  localparam logic [2:0] STAT_PASSIVE = 3'b111;

  function automatic logic [2:0] cycle_code(input logic io, input logic wr);
    logic [2:0] c;
    case ({io, wr})
      2'b00:   c = 3'b101;
      2'b01:   c = 3'b110;
      2'b10:   c = 3'b001;
      default: c = 3'b010;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/mxb_phase_fsm.sv
module mxb_phase_fsm
  import mxb_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_io,
  input  logic              req_bhe_n,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [DATA_W-1:0] req_wdata,
  output phase_e            phase,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cur_write,
  output logic              cur_io,
  output logic              cur_bhe_n,
  output logic [SEG_W-1:0]  cur_seg,
  output logic [DATA_W-1:0] cur_wdata
);
  phase_e phase_nx;
  logic   take;

  assign req_ready = (phase == PH_IDLE) || (phase == PH_T4);
  assign take      = req_valid && req_ready;

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_IDLE: if (take) phase_nx = PH_T1;
      PH_T1:   phase_nx = PH_T2;
      PH_T2:   phase_nx = PH_T3;
      PH_T3:   phase_nx = PH_T4;
      PH_T4:   phase_nx = take ? PH_T1 : PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cur_addr  <= '0;
      cur_write <= 1'b0;
      cur_io    <= 1'b0;
      cur_bhe_n <= 1'b1;
      cur_seg   <= '0;
      cur_wdata <= '0;
    end else begin
      phase <= phase_nx;
      if (take) begin
        cur_addr  <= req_addr;
        cur_write <= req_write;
        cur_io    <= req_io;
        cur_bhe_n <= req_bhe_n;
        cur_seg   <= req_seg;
        cur_wdata <= req_wdata;
      end
    end
  end
endmodule

// File: rtl/mxb_pin_mux.sv
module mxb_pin_mux
  import mxb_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 2
) (
  input  phase_e                   phase,
  input  logic                     mode_min,
  input  logic [ADDR_W-1:0]        cur_addr,
  input  logic                     cur_write,
  input  logic                     cur_io,
  input  logic                     cur_bhe_n,
  input  logic [SEG_W-1:0]         cur_seg,
  input  logic [DATA_W-1:0]        cur_wdata,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] ah_out,
  output logic                     bhe_out,
  output logic                     ale,
  output logic [2:0]               status,
  output logic                     rd_n,
  output logic                     wr_n
);
  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int PAD_W = HI_W - SEG_W;

  logic [HI_W-1:0] stat_hi;
  logic            strobe_win;
  logic            data_win;

  generate
    if (PAD_W > 0) begin : g_pad
      assign stat_hi = {{PAD_W{1'b0}}, cur_seg};
    end else begin : g_nopad
      assign stat_hi = cur_seg[HI_W-1:0];
    end
  endgenerate

  assign strobe_win = (phase == PH_T2) || (phase == PH_T3);
  assign data_win   = strobe_win || (phase == PH_T4);

  always_comb begin
    ad_out  = '0;
    ad_oe   = 1'b0;
    ah_out  = '0;
    bhe_out = 1'b1;
    ale     = 1'b0;
    status  = STAT_PASSIVE;
    rd_n    = 1'b1;
    wr_n    = 1'b1;
    if (phase == PH_T1) begin
      ale     = 1'b1;
      ad_oe   = 1'b1;
      ad_out  = cur_addr[DATA_W-1:0];
      ah_out  = cur_addr[ADDR_W-1:DATA_W];
      bhe_out = cur_bhe_n;
      status  = cycle_code(cur_io, cur_write);
    end else if (data_win) begin
      ah_out  = stat_hi;
      bhe_out = 1'b0;
      ad_oe   = cur_write;
      ad_out  = cur_write ? cur_wdata : '0;
      if (strobe_win) begin
        status = cycle_code(cur_io, cur_write);
        rd_n   = !(mode_min && !cur_write);
        wr_n   = !(mode_min && cur_write);
      end
    end
  end
endmodule

// File: rtl/mxb_addr_latch.sv
module mxb_addr_latch #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ale,
  input  logic [DATA_W-1:0]        ad_out,
  input  logic [ADDR_W-DATA_W-1:0] ah_out,
  output logic [ADDR_W-1:0]        latched_addr
);
  always_ff @(posedge clk) begin
    if (rst)      latched_addr <= '0;
    else if (ale) latched_addr <= {ah_out, ad_out};
  end
endmodule

// File: rtl/mxb_read_capture.sv
module mxb_read_capture
  import mxb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase,
  input  logic              cur_write,
  input  logic [DATA_W-1:0] ad_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  assign rsp_valid = (phase == PH_T4);

  always_ff @(posedge clk) begin
    if (rst)                                rsp_rdata <= '0;
    else if (phase == PH_T3 && !cur_write)  rsp_rdata <= ad_in;
  end
endmodule

// File: rtl/mxbus_seq.sv
module mxbus_seq
  import mxb_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mode_min,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic                     req_io,
  input  logic                     req_bhe_n,
  input  logic [SEG_W-1:0]         req_seg,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] ah_out,
  output logic                     bhe_out,
  output logic                     ale,
  output logic [2:0]               status,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [ADDR_W-1:0]        latched_addr,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata
);
  phase_e            phase;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_write, cur_io, cur_bhe_n;
  logic [SEG_W-1:0]  cur_seg;
  logic [DATA_W-1:0] cur_wdata;

  mxb_phase_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_io(req_io),
    .req_bhe_n(req_bhe_n), .req_seg(req_seg), .req_wdata(req_wdata),
    .phase(phase), .cur_addr(cur_addr), .cur_write(cur_write),
    .cur_io(cur_io), .cur_bhe_n(cur_bhe_n), .cur_seg(cur_seg),
    .cur_wdata(cur_wdata)
  );

  mxb_pin_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) u_mux (
    .phase(phase), .mode_min(mode_min), .cur_addr(cur_addr),
    .cur_write(cur_write), .cur_io(cur_io), .cur_bhe_n(cur_bhe_n),
    .cur_seg(cur_seg), .cur_wdata(cur_wdata), .ad_out(ad_out),
    .ad_oe(ad_oe), .ah_out(ah_out), .bhe_out(bhe_out), .ale(ale),
    .status(status), .rd_n(rd_n), .wr_n(wr_n)
  );

  mxb_addr_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .ale(ale), .ad_out(ad_out), .ah_out(ah_out),
    .latched_addr(latched_addr)
  );

  mxb_read_capture #(.DATA_W(DATA_W)) u_rcap (
    .clk(clk), .rst(rst), .phase(phase), .cur_write(cur_write),
    .ad_in(ad_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/mxbus_seq_chk.sv
module mxbus_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_min,
  input logic              req_valid,
  input logic              req_ready,
  input logic              ale,
  input logic [2:0]        status,
  input logic              rd_n,
  input logic              wr_n,
  input logic [ADDR_W-1:0] latched_addr,
  input logic              rsp_valid
);
  p_ale_single_r2: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);
  p_accept_to_t1_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> ale);
  p_busy_in_t1_r2: assert property (@(posedge clk) disable iff (rst)
    ale |-> !req_ready);
  p_done_passive_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (status == 3'b111));
  p_done_after_t1_r7: assert property (@(posedge clk) disable iff (rst)
    ale |-> ##3 rsp_valid);
  p_max_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !mode_min |-> (rd_n && wr_n));
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (rd_n || wr_n));
  p_latch_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!ale && !$past(ale)) |-> $stable(latched_addr));
endmodule

bind mxbus_seq mxbus_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mode_min(mode_min), .req_valid(req_valid),
  .req_ready(req_ready), .ale(ale), .status(status), .rd_n(rd_n),
  .wr_n(wr_n), .latched_addr(latched_addr), .rsp_valid(rsp_valid)
);

// File: tb/mxbus_seq_test.sv
`timescale 1ns/1ps
module mxbus_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_min = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        req_write = 1'b0, req_io = 1'b0, req_bhe_n = 1'b1;
  logic [1:0]  req_seg = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] ad_out, ad_in = '0, rsp_rdata;
  logic        ad_oe, bhe_out, ale, rd_n, wr_n, rsp_valid;
  logic [3:0]  ah_out;
  logic [2:0]  status;
  logic [19:0] latched_addr;

  always #2.5 clk = ~clk;

  mxbus_seq uut (.*);

  typedef struct {
    logic [19:0] addr;
    logic        wr, io, bhe_n;
    logic [1:0]  seg;
    logic [15:0] wdata, rdata;
    logic        mmin;
  } item_t;

  item_t q[$];
  int n_cmp = 0, n_bad = 0, n_issued = 0, n_done = 0;
  bit done_flag = 0;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [2:0] code_of(logic io, logic wr);
    if (!io && !wr) return 3'b101;
    if (!io &&  wr) return 3'b110;
    if ( io && !wr) return 3'b001;
    return 3'b010;
  endfunction

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // driver: called at a falling edge
  task automatic issue(logic [19:0] a, logic wr, logic io, logic bn,
                       logic [1:0] sg, logic [15:0] wd, logic [15:0] rd);
    item_t it;
    while (!req_ready) @(negedge clk);
    req_addr = a; req_write = wr; req_io = io; req_bhe_n = bn;
    req_seg = sg; req_wdata = wd; req_valid = 1'b1;
    it.addr = a; it.wr = wr; it.io = io; it.bhe_n = bn; it.seg = sg;
    it.wdata = wd; it.rdata = rd; it.mmin = mode_min;
    q.push_back(it);
    n_issued++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    item_t e;
    logic [2:0] c;
    forever begin
      @(negedge clk);
      if (!rst && ale) begin
        if (q.size() == 0) begin
          chk("R2 unexpected cycle start", 1, 0);
        end else begin
          e = q.pop_front();
          c = code_of(e.io, e.wr);
          chk("R3 T1 ad_out",  ad_out, e.addr[15:0]);
          chk("R3 T1 ad_oe",   ad_oe, 1);
          chk("R3 T1 ah_out",  ah_out, e.addr[19:16]);
          chk("R3 T1 bhe_out", bhe_out, e.bhe_n);
          chk("R5 T1 status",  status, c);
          chk("R2 T1 ready",   req_ready, 0);
          for (int t = 2; t <= 4; t++) begin
            @(negedge clk);
            if (t == 2) ad_in = e.rdata;
            chk("R2 ale low after T1", ale, 0);
            chk("R4 status on ah_out", ah_out, {2'b00, e.seg});
            chk("R4 bhe_out status", bhe_out, 0);
            chk("R9 latched_addr", latched_addr, e.addr);
            chk("R2 ready", req_ready, (t == 4));
            if (e.wr) begin
              chk("R6 write oe", ad_oe, 1);
              chk("R6 write data", ad_out, e.wdata);
            end else begin
              chk("R7 read releases pins", ad_oe, 0);
            end
            if (t < 4) begin
              chk("R5 status T2/T3", status, c);
              chk("R8 rd_n", rd_n, !(e.mmin && !e.wr));
              chk("R8 wr_n", wr_n, !(e.mmin && e.wr));
              chk("R7 no done before T4", rsp_valid, 0);
            end else begin
              chk("R5 status passive T4", status, 3'b111);
              chk("R8 rd_n T4", rd_n, 1);
              chk("R8 wr_n T4", wr_n, 1);
              chk("R7 done in T4", rsp_valid, 1);
              if (!e.wr) chk("R7 read data", rsp_rdata, e.rdata);
            end
          end
          ad_in = 16'h0000;
          n_done++;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    finish_run();
  end

  task automatic check_idle(string tag_r2, logic [19:0] la);
    chk({tag_r2, " idle ale"}, ale, 0);
    chk("R5 idle passive", status, 3'b111);
    chk("R7 idle no done", rsp_valid, 0);
    chk("R2 idle ready", req_ready, 1);
    chk("R9 idle latch hold", latched_addr, la);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state during reset
    chk("R1 ale", ale, 0);
    chk("R1 ad_oe", ad_oe, 0);
    chk("R1 rd_n", rd_n, 1);
    chk("R1 wr_n", wr_n, 1);
    chk("R1 status", status, 3'b111);
    chk("R1 ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 latched_addr", latched_addr, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset ale", ale, 0);
    chk("R1 after reset status", status, 3'b111);

    // minimum mode: four cycle kinds
    mode_min = 1'b1;
    issue(20'hA5C3E, 1'b0, 1'b0, 1'b0, 2'b01, 16'h0000, 16'h5A3C);
    issue(20'h3C1A5, 1'b1, 1'b0, 1'b1, 2'b10, 16'hC3A5, 16'h0000);
    issue(20'h0F0F0, 1'b0, 1'b1, 1'b0, 2'b11, 16'h0000, 16'hA55A);
    issue(20'hF0F0F, 1'b1, 1'b1, 1'b1, 2'b00, 16'h1234, 16'h0000);
    wait (n_done == n_issued);
    @(negedge clk);
    check_idle("R2", 20'hF0F0F);

    // back-to-back: second taken in T4
    issue(20'h12345, 1'b0, 1'b0, 1'b1, 2'b10, 16'h0000, 16'hFEDC);
    issue(20'h6789A, 1'b1, 1'b0, 1'b0, 2'b01, 16'hBEEF, 16'h0000);
    wait (n_done == n_issued);
    @(negedge clk);
    check_idle("R2 back-to-back", 20'h6789A);

    // maximum mode
    mode_min = 1'b0;
    issue(20'h55AA5, 1'b0, 1'b0, 1'b0, 2'b11, 16'h0000, 16'h0FF0);
    issue(20'hAA55A, 1'b1, 1'b1, 1'b1, 2'b01, 16'h8001, 16'h0000);
    wait (n_done == n_issued);
    // R9 long idle: latch holds
    repeat (8) @(negedge clk);
    check_idle("R2 long idle", 20'hAA55A);
    chk("R2 queue drained", q.size(), 0);
    finish_run();
  end
endmodule